// File: doc/BRIEF.md
# Path signal label monitor

This block watches the path signal label byte that a framer extracts once per frame. A strobe marks each new sample. The block filters the samples into an accepted label, and it accepts a value only after the same byte has arrived in several consecutive frames. It compares the accepted label with a programmable expected label and raises two alarms. The mismatch alarm flags a wrong payload type. The unequipped alarm flags a path that carries no payload.

Each change of the accepted label and each change of an alarm sets a sticky delta flag, which software clears by writing one to it. A small register interface gives access to the delta flags and the expected label, and lets software read back the accepted label and the live alarms. The accepted label and both alarms are also driven straight out as ports for use by nearby logic.

Top module: `lblmon_top`

## Requirements
- R1: A byte becomes the accepted label on the clock edge that samples the fifth consecutive strobe carrying that same byte (PERSIST = 5). No strobe ever changes the accepted label before the fifth.
- R2: A strobe whose byte differs from the byte of the previous strobe restarts the consecutive count at one. Cycles without a strobe do not break a run.
- R3: Delta bit 4 is set on the edge that stores a new value into the accepted label. The first acceptance after reset always counts as new, and accepting the value already held does not set the bit.
- R4: The expected label is read and written at address 1, and it resets to 0x18.
- R5: The mismatch alarm is 1 when a label has been accepted, the accepted label differs from the expected label, and the accepted label is none of 0x00, 0x01, 0xFC or 0xFF.
- R6: The unequipped alarm is 1 when a label has been accepted, the accepted label is 0x00 and the expected label is not 0x00.
- R7: Both alarms stay 0 until the first label is accepted. After that they are re-evaluated one cycle after any change of the accepted or expected label, and each clears when its condition no longer holds.
- R8: Delta bit 1 is set when the mismatch alarm changes state, and delta bit 2 is set when the unequipped alarm changes state, on the same edge as the change.
- R9: A write to address 0 clears every delta bit whose data bit is one. Zero data bits leave their delta bits unchanged. A set event in the same cycle as a clear wins.
- R10: The read data shows the delta flags at address 0 (bits 7–5, 3 and 0 read as zero), the accepted label at address 2, and the status at address 3 (bit 0 mismatch, bit 1 unequipped, the other bits zero). After reset the accepted label is 0x00, the alarms are 0 and all delta bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fr_stb | input | 1 | One-cycle strobe marking a new label sample |
| fr_byte | input | 8 | Received label byte, valid with fr_stb |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| acc_label | output | 8 | Currently accepted label |
| mismatch | output | 1 | Label mismatch alarm |
| unequipped | output | 1 | Unequipped path alarm |

## Verification
The bench builds the block with its default parameters, so a label needs five matching strobes and the label is a byte. This makes the boundary between four and five frames reachable in a few dozen cycles. It also lets directed runs broken by one odd byte show the count restarting. Every special label code and both alarm transitions are driven. A register write is placed in the exact cycle in which an alarm change sets the same delta bit.

// File: rtl/lblmon_pkg.sv
`timescale 1ns/1ps
package lblmon_pkg;

    localparam int LBL_W = 8;
    typedef logic [LBL_W-1:0] lbl_t;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_DELTA  = 2'd0;
    localparam logic [ADDR_W-1:0] A_EXPECT = 2'd1;
    localparam logic [ADDR_W-1:0] A_ACCEPT = 2'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

    localparam int DB_MM  = 1;
    localparam int DB_UN  = 2;
    localparam int DB_CHG = 4;

    localparam lbl_t EXPECT_RST = 8'h18;

    typedef struct packed {
        logic chg;
        logic un;
        logic mm;
    } delta_t;

    function automatic logic lbl_special(lbl_t v);
        return (v == 8'h00) || (v == 8'h01) || (v == 8'hFC) || (v == 8'hFF);
    endfunction

endpackage

// File: rtl/lblmon_persist.sv
`timescale 1ns/1ps
module lblmon_persist
    import lblmon_pkg::*;
#(
    parameter int PERSIST = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  lbl_t byte_i,
    output lbl_t acc_o,
    output logic valid_o,
    output logic store_o
);
    localparam int CNT_W = $clog2(PERSIST + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PERSIST);

    typedef struct packed {
        lbl_t             prev;
        logic [CNT_W-1:0] cnt;
        lbl_t             acc;
        logic             valid;
    } st_t;

    st_t  s_d, s_q;
    logic store_d;

    always_comb begin
        s_d     = s_q;
        store_d = 1'b0;
        if (stb_i) begin
            if ((s_q.cnt != '0) && (byte_i == s_q.prev)) begin
                if (s_q.cnt < CNT_TOP) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else begin
                s_d.cnt  = CNT_W'(1);
                s_d.prev = byte_i;
            end
            if ((s_d.cnt == CNT_TOP) && (!s_q.valid || (byte_i != s_q.acc))) begin
                s_d.acc   = byte_i;
                s_d.valid = 1'b1;
                store_d   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_o   = s_q.acc;
    assign valid_o = s_q.valid;
    assign store_o = store_d;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_TOP);
    p_acc_on_stb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(s_q.acc));
    p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |=> s_q.valid);

endmodule

// File: rtl/lblmon_alarm.sv
`timescale 1ns/1ps
module lblmon_alarm
    import lblmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  lbl_t acc_i,
    input  lbl_t exp_i,
    input  logic valid_i,
    output logic mm_o,
    output logic un_o,
    output logic mm_flip_o,
    output logic un_flip_o
);
    typedef struct packed {
        logic mm;
        logic un;
    } al_t;

    al_t al_d, al_q;

    always_comb begin
        al_d.mm = valid_i && (acc_i != exp_i) && !lbl_special(acc_i);
        al_d.un = valid_i && (acc_i == '0) && (exp_i != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_q <= '0;
        end else begin
            al_q <= al_d;
        end
    end

    assign mm_o      = al_q.mm;
    assign un_o      = al_q.un;
    assign mm_flip_o = al_d.mm != al_q.mm;
    assign un_flip_o = al_d.un != al_q.un;

    p_alarm_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(al_q.mm && al_q.un));
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (!al_q.mm && !al_q.un));

endmodule

// File: rtl/lblmon_regs.sv
`timescale 1ns/1ps
module lblmon_regs
    import lblmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  lbl_t              wdata_i,
    input  logic              store_i,
    input  logic              mm_flip_i,
    input  logic              un_flip_i,
    input  lbl_t              acc_i,
    input  logic              mm_i,
    input  logic              un_i,
    output lbl_t              exp_o,
    output delta_t            delta_o,
    output lbl_t              rdata_o
);
    typedef struct packed {
        lbl_t   expl;
        delta_t dl;
    } rg_t;

    rg_t    r_d, r_q;
    delta_t clr, setv;

    always_comb begin
        clr  = '0;
        setv = '0;
        r_d  = r_q;
        if (wr_i && (addr_i == A_DELTA)) begin
            clr.chg = wdata_i[DB_CHG];
            clr.un  = wdata_i[DB_UN];
            clr.mm  = wdata_i[DB_MM];
        end
        if (wr_i && (addr_i == A_EXPECT)) begin
            r_d.expl = wdata_i;
        end
        setv.chg = store_i;
        setv.un  = un_flip_i;
        setv.mm  = mm_flip_i;
        r_d.dl   = (r_q.dl & ~clr) | setv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.expl <= EXPECT_RST;
            r_q.dl   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_DELTA: begin
                rdata_o[DB_CHG] = r_q.dl.chg;
                rdata_o[DB_UN]  = r_q.dl.un;
                rdata_o[DB_MM]  = r_q.dl.mm;
            end
            A_EXPECT: rdata_o = r_q.expl;
            A_ACCEPT: rdata_o = acc_i;
            A_STATUS: begin
                rdata_o[0] = mm_i;
                rdata_o[1] = un_i;
            end
            default: rdata_o = '0;
        endcase
    end

    assign exp_o   = r_q.expl;
    assign delta_o = r_q.dl;

    p_w0_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_DELTA && wdata_i == '0) |=> ((r_q.dl & $past(r_q.dl)) == $past(r_q.dl)));
    p_exp_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_EXPECT) |=> (r_q.expl == $past(wdata_i)));
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == A_DELTA) |-> (rdata_o[7:5] == 3'b000 && !rdata_o[3] && !rdata_o[0]));

endmodule

// File: rtl/lblmon_top.sv
`timescale 1ns/1ps
module lblmon_top
    import lblmon_pkg::*;
#(
    parameter int PERSIST = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fr_stb,
    input  logic [7:0] fr_byte,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [7:0] acc_label,
    output logic       mismatch,
    output logic       unequipped
);
    lbl_t   acc_w, exp_w;
    logic   valid_w, store_w, mm_w, un_w, mm_flip_w, un_flip_w;
    delta_t delta_w;

    lblmon_persist #(.PERSIST(PERSIST)) u_persist (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (fr_stb),
        .byte_i  (fr_byte),
        .acc_o   (acc_w),
        .valid_o (valid_w),
        .store_o (store_w)
    );

    lblmon_alarm u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_i     (acc_w),
        .exp_i     (exp_w),
        .valid_i   (valid_w),
        .mm_o      (mm_w),
        .un_o      (un_w),
        .mm_flip_o (mm_flip_w),
        .un_flip_o (un_flip_w)
    );

    lblmon_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .store_i   (store_w),
        .mm_flip_i (mm_flip_w),
        .un_flip_i (un_flip_w),
        .acc_i     (acc_w),
        .mm_i      (mm_w),
        .un_i      (un_w),
        .exp_o     (exp_w),
        .delta_o   (delta_w),
        .rdata_o   (reg_rdata)
    );

    assign acc_label  = acc_w;
    assign mismatch   = mm_w;
    assign unequipped = un_w;

    p_mm_delta_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mm_w) |-> delta_w.mm);
    p_un_delta_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(un_w) |-> delta_w.un);
    p_chg_delta_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_w) |-> delta_w.chg);

endmodule

// File: tb/sim_lblmon_top.sv
`timescale 1ns/1ps
module sim_lblmon_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fr_stb = 1'b0;
    logic [7:0] fr_byte = '0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, acc_label;
    logic       mismatch, unequipped;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int m_acc, m_exp, m_valid, m_mm, m_un, m_del, m_prev, m_cnt;

    always #(CLK_P/2) clk = ~clk;

    lblmon_top u0 (
        .clk(clk), .rst_n(rst_n), .fr_stb(fr_stb), .fr_byte(fr_byte),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .acc_label(acc_label),
        .mismatch(mismatch), .unequipped(unequipped)
    );

    function automatic bit spec(int v);
        return v == 0 || v == 1 || v == 'hFC || v == 'hFF;
    endfunction

    function automatic int model_rd(int a);
        case (a)
            0: return m_del;
            1: return m_exp;
            2: return m_acc;
            default: return m_mm + 2 * m_un;
        endcase
    endfunction

    // reference model, advanced on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_exp = 'h18; m_valid = 0; m_mm = 0; m_un = 0;
            m_del = 0; m_prev = 0; m_cnt = 0;
        end else begin
            int mmn, unn, setb, clrb;
            mmn  = (m_valid != 0 && m_acc != m_exp && !spec(m_acc)) ? 1 : 0;
            unn  = (m_valid != 0 && m_acc == 0 && m_exp != 0) ? 1 : 0;
            setb = 0;
            if (mmn != m_mm) setb = setb | 'h02;
            if (unn != m_un) setb = setb | 'h04;
            if (fr_stb) begin
                if (m_cnt != 0 && int'(fr_byte) == m_prev) begin
                    if (m_cnt < 5) m_cnt = m_cnt + 1;
                end else begin
                    m_cnt = 1;
                    m_prev = int'(fr_byte);
                end
                if (m_cnt == 5 && (m_valid == 0 || int'(fr_byte) != m_acc)) begin
                    m_acc = int'(fr_byte);
                    m_valid = 1;
                    setb = setb | 'h10;
                end
            end
            clrb  = (reg_wr && reg_addr == 0) ? int'(reg_wdata) : 0;
            m_del = ((m_del & ~clrb) | setb) & 'h16;
            if (reg_wr && reg_addr == 1) m_exp = int'(reg_wdata);
            m_mm = mmn;
            m_un = unn;
        end
    end

    task automatic chk(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && !done) begin
            chk("R1 acc_label", int'(acc_label), m_acc);
            chk("R5 mismatch", int'(mismatch), m_mm);
            chk("R6 unequipped", int'(unequipped), m_un);
            chk("R10 reg_rdata", int'(reg_rdata), model_rd(int'(reg_addr)));
        end
    end

    task automatic frame(input logic [7:0] b);
        @(negedge clk); fr_stb = 1'b1; fr_byte = b;
        @(negedge clk); fr_stb = 1'b0;
    endtask

    task automatic frames(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) frame(b);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, input int expv, input string tag);
        @(negedge clk); reg_addr = a;
        #1;
        chk(tag, int'(reg_rdata), expv);
        reg_addr = 2'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        rd(2'd1, 'h18, "R4 expected label reset");
        rd(2'd0, 'h00, "R10 delta reset");
        rd(2'd2, 'h00, "R10 accepted reset");
        rd(2'd3, 'h00, "R10 status reset");

        frames(8'h18, 4);
        chk("R1 four frames not accepted", int'(acc_label), 'h00);
        rd(2'd0, 'h00, "R3 no delta before acceptance");
        frame(8'h18);
        chk("R1 accepted on fifth", int'(acc_label), 'h18);
        rd(2'd0, 'h10, "R3 first acceptance sets delta");
        idle(2);
        chk("R7 no alarm when matching", int'(mismatch) + int'(unequipped), 0);
        wreg(2'd0, 8'h10);
        rd(2'd0, 'h00, "R9 write one clears");

        frames(8'h20, 4);
        frame(8'h21);
        chk("R2 odd byte breaks run", int'(acc_label), 'h18);
        frames(8'h20, 4);
        chk("R2 count restarted at one", int'(acc_label), 'h18);
        frame(8'h20);
        chk("R1 accepted after restart", int'(acc_label), 'h20);
        idle(2);
        chk("R5 mismatch raised", int'(mismatch), 1);
        rd(2'd0, 'h12, "R8 mismatch delta");
        wreg(2'd0, 8'h00);
        rd(2'd0, 'h12, "R9 zero write keeps");
        wreg(2'd0, 8'h02);
        rd(2'd0, 'h10, "R9 partial clear");
        frames(8'h20, 5);
        rd(2'd0, 'h10, "R3 same value no new delta");
        wreg(2'd0, 8'h10);

        wreg(2'd1, 8'h20);
        idle(2);
        chk("R7 expected change clears mismatch", int'(mismatch), 0);
        rd(2'd1, 'h20, "R4 expected readback");
        rd(2'd0, 'h02, "R8 mismatch fall delta");

        frames(8'hFC, 5);
        idle(2);
        chk("R5 0xFC exempt", int'(mismatch), 0);
        frames(8'h01, 5);
        idle(2);
        chk("R5 0x01 exempt", int'(mismatch), 0);
        frames(8'hFF, 5);
        idle(2);
        chk("R5 0xFF exempt", int'(mismatch), 0);
        frames(8'h00, 5);
        idle(2);
        chk("R6 unequipped raised", int'(unequipped), 1);
        chk("R5 0x00 exempt", int'(mismatch), 0);
        rd(2'd3, 'h02, "R10 status unequipped");
        wreg(2'd1, 8'h00);
        idle(2);
        chk("R6 zero expected clears unequipped", int'(unequipped), 0);
        wreg(2'd0, 8'hFF);
        rd(2'd0, 'h00, "R10 all delta cleared");

        // set and clear collide on the unequipped delta bit
        @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h18;
        @(negedge clk); reg_addr = 2'd0; reg_wdata = 8'h04;
        @(negedge clk); reg_wr = 1'b0;
        rd(2'd0, 'h04, "R9 set wins over clear");
        chk("R6 unequipped after expected set", int'(unequipped), 1);
        rd(2'd2, 'h00, "R10 accepted readback");

        idle(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule